// File: doc/BRIEF.md
# Non-binary check-node minimum finder

This block is the front end of a min-max check-node unit in a non-binary LDPC decoder over GF(2^p). Each transaction carries `DC` variable-to-check message vectors. A vector holds `Q = 2^p` reliability values, one for each field symbol, together with that position's hard-decision symbol. Reliability values are unsigned and smaller means more reliable. Each vector is normalised so that the value at its hard-decision symbol is 0.

The block XORs the hard decisions of all positions into a syndrome-like sum. It reindexes every vector by its own hard decision, which puts the most reliable symbol at offset 0. For every nonzero offset it finds the smallest value, the position that holds it, and the second-smallest value. It then builds, for every position, a vector that takes the best value from all the other positions.

The work runs in a three-stage pipeline that accepts one full check-node input per cycle. The results are the per-position exclusion vectors, the per-position hard decisions and the XOR sum. A later sorting and path-construction stage consumes them.

Top module: `cn_min_front`

## Requirements
- R1: `out_sum` equals the bitwise XOR of the `DC` hard-decision symbols of the transaction.
- R2: `out_hard` returns each position's hard-decision symbol unchanged, at the same bit positions as `in_hard`. Position j occupies bits [j*P +: P].
- R3: The shifted value of position j at offset b is the input value of position j at symbol (b XOR hard_j). Value (j, s) of a vector is carried on bits [(j*Q+s)*W +: W] of `in_llr`.
- R4: For every nonzero offset b, the minimum m1(b) over all positions is found together with its position I(b). On equal values the lower position index is taken as I(b). The second minimum m2(b) is the smallest value among the remaining positions, so m2(b) equals m1(b) when the minimum occurs twice.
- R5: For every position j and nonzero offset b, `out_msg` entry (j, b) equals m2(b) when j equals I(b), and m1(b) otherwise. It uses the same bit layout as `in_llr`.
- R6: Entry (j, 0) of `out_msg` is 0 for every position.
- R7: `in_ready` is high whenever the block is out of reset. Each accepted transaction (in_valid and in_ready high at a rising edge) produces exactly one cycle of `out_valid`, three rising edges after acceptance, and `out_valid` is never high otherwise. Back-to-back transactions are accepted on consecutive cycles.
- R8: While `rst` is held high, `out_valid` and `in_ready` are low from the first rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A check-node input is present |
| in_ready | output | 1 | Block accepts an input this cycle |
| in_llr | input | DC*Q*W | Reliability values, position-major then symbol |
| in_hard | input | DC*P | Hard-decision symbol per position |
| out_valid | output | 1 | Results valid for one cycle |
| out_msg | output | DC*Q*W | Exclusion vectors, position-major then offset |
| out_hard | output | DC*P | Hard-decision symbols of the result |
| out_sum | output | P | XOR of all hard decisions |

## Verification
The bench targets ties in the minimum search. It sends vectors where every position holds the same value and vectors where two positions share the minimum. A design that picked the higher index, or that let the second minimum skip an equal value, would give the wrong position a larger entry. A descending pattern puts the unique minimum at the last position, which catches an off-by-one scan that drops the final position. All-maximum values catch saturation of the initial search values. Random hard decisions exercise the reindexing, so a design that shifted by the wrong symbol would place values under the wrong offsets. Back-to-back inputs and inputs with gaps between them check that each result appears exactly three edges after its input and that no result is lost or repeated.

// File: rtl/cnm_pkg.sv
package cnm_pkg;
  localparam int DEF_P  = 2;
  localparam int DEF_DC = 6;
  localparam int DEF_W  = 6;

  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cnm_shift.sv
module cnm_shift #(
  parameter int P  = cnm_pkg::DEF_P,
  parameter int DC = cnm_pkg::DEF_DC,
  parameter int W  = cnm_pkg::DEF_W,
  localparam int Q = 1 << P
) (
  input  logic [DC*Q*W-1:0] llr,
  input  logic [DC*P-1:0]   hard,
  output logic [DC*Q*W-1:0] shifted,
  output logic [P-1:0]      hsum
);
  for (genvar j = 0; j < DC; j++) begin : g_pos
    for (genvar b = 0; b < Q; b++) begin : g_off
      localparam logic [P-1:0] OFF = P'(b);
      logic [P-1:0] src;
      assign src = OFF ^ hard[j*P +: P];
      assign shifted[(j*Q+b)*W +: W] = llr[(j*Q + int'(src))*W +: W];
    end
  end

  always_comb begin
    hsum = '0;
    for (int j = 0; j < DC; j++) hsum = hsum ^ hard[j*P +: P];
  end
endmodule

// File: rtl/cnm_min2.sv
module cnm_min2 #(
  parameter int DC = cnm_pkg::DEF_DC,
  parameter int W  = cnm_pkg::DEF_W,
  localparam int IW = cnm_pkg::idx_bits(DC)
) (
  input  logic [DC*W-1:0] vals,
  output logic [W-1:0]    m1,
  output logic [W-1:0]    m2,
  output logic [IW-1:0]   idx
);
  always_comb begin
    m1  = '1;
    m2  = '1;
    idx = '0;
    for (int j = 0; j < DC; j++) begin
      if (vals[j*W +: W] < m1) begin
        m2  = m1;
        m1  = vals[j*W +: W];
        idx = IW'(j);
      end else if (vals[j*W +: W] < m2) begin
        m2 = vals[j*W +: W];
      end
    end
  end
endmodule

// File: rtl/cnm_select.sv
module cnm_select #(
  parameter int P  = cnm_pkg::DEF_P,
  parameter int DC = cnm_pkg::DEF_DC,
  parameter int W  = cnm_pkg::DEF_W,
  localparam int Q  = 1 << P,
  localparam int IW = cnm_pkg::idx_bits(DC)
) (
  input  logic [Q*W-1:0]    m1,
  input  logic [Q*W-1:0]    m2,
  input  logic [Q*IW-1:0]   idx,
  output logic [DC*Q*W-1:0] msg
);
  for (genvar j = 0; j < DC; j++) begin : g_pos
    assign msg[(j*Q)*W +: W] = '0;
    for (genvar b = 1; b < Q; b++) begin : g_off
      assign msg[(j*Q+b)*W +: W] =
        (idx[b*IW +: IW] == IW'(j)) ? m2[b*W +: W] : m1[b*W +: W];
    end
  end
endmodule

// File: rtl/cn_min_front.sv
module cn_min_front #(
  parameter int P  = cnm_pkg::DEF_P,
  parameter int DC = cnm_pkg::DEF_DC,
  parameter int W  = cnm_pkg::DEF_W,
  localparam int Q  = 1 << P,
  localparam int IW = cnm_pkg::idx_bits(DC),
  localparam int VB = DC*Q*W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VB-1:0]    in_llr,
  input  logic [DC*P-1:0]  in_hard,
  output logic             out_valid,
  output logic [VB-1:0]    out_msg,
  output logic [DC*P-1:0]  out_hard,
  output logic [P-1:0]     out_sum
);
  logic rdy_q;
  logic accept;
  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;

  always_ff @(posedge clk) rdy_q <= ~rst;

  // Stage 1: reindex and hard-decision sum
  logic [VB-1:0]   sh_c;
  logic [P-1:0]    sum_c;
  logic            v1;
  logic [VB-1:0]   sh1;
  logic [DC*P-1:0] hard1;
  logic [P-1:0]    sum1;

  cnm_shift #(.P(P), .DC(DC), .W(W)) shift_i (
    .llr(in_llr), .hard(in_hard), .shifted(sh_c), .hsum(sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; sh1 <= '0; hard1 <= '0; sum1 <= '0;
    end else begin
      v1 <= accept;
      if (accept) begin
        sh1 <= sh_c; hard1 <= in_hard; sum1 <= sum_c;
      end
    end
  end

  // Stage 2: per-offset first/second minimum
  logic [Q*W-1:0]  m1_c, m2_c;
  logic [Q*IW-1:0] idx_c;
  logic            v2;
  logic [Q*W-1:0]  m1_2, m2_2;
  logic [Q*IW-1:0] idx2;
  logic [DC*P-1:0] hard2;
  logic [P-1:0]    sum2;

  assign m1_c[0 +: W]   = '0;
  assign m2_c[0 +: W]   = '0;
  assign idx_c[0 +: IW] = '0;

  for (genvar b = 1; b < Q; b++) begin : g_col
    logic [DC*W-1:0] col;
    for (genvar j = 0; j < DC; j++) begin : g_gather
      assign col[j*W +: W] = sh1[(j*Q+b)*W +: W];
    end
    cnm_min2 #(.DC(DC), .W(W)) min_i (
      .vals(col), .m1(m1_c[b*W +: W]), .m2(m2_c[b*W +: W]),
      .idx(idx_c[b*IW +: IW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; m1_2 <= '0; m2_2 <= '0; idx2 <= '0;
      hard2 <= '0; sum2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        m1_2 <= m1_c; m2_2 <= m2_c; idx2 <= idx_c;
        hard2 <= hard1; sum2 <= sum1;
      end
    end
  end

  // Stage 3: per-position exclusion vectors
  logic [VB-1:0] msg_c;

  cnm_select #(.P(P), .DC(DC), .W(W)) sel_i (
    .m1(m1_2), .m2(m2_2), .idx(idx2), .msg(msg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_msg <= '0; out_hard <= '0; out_sum <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        out_msg <= msg_c; out_hard <= hard2; out_sum <= sum2;
      end
    end
  end

  // Checks
  logic [P-1:0] chk_sum;
  always_comb begin
    chk_sum = '0;
    for (int j = 0; j < DC; j++) chk_sum = chk_sum ^ out_hard[j*P +: P];
  end

  AST_SUM_MATCHES_HARD: assert property (@(posedge clk) disable iff (rst) out_valid |-> (chk_sum == out_sum)); // R1
  AST_ACCEPT_FLOWS: assert property (@(posedge clk) disable iff (rst) accept |=> v1); // R7
  AST_STAGE2_FLOWS: assert property (@(posedge clk) disable iff (rst) v1 |=> v2); // R7
  AST_OUT_FLOWS: assert property (@(posedge clk) disable iff (rst) v2 |=> out_valid); // R7
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(v2)); // R7

  for (genvar b = 1; b < Q; b++) begin : g_chk
    AST_MIN_ORDER: assert property (@(posedge clk) disable iff (rst) v2 |-> (m1_2[b*W +: W] <= m2_2[b*W +: W])); // R4
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) v2 |-> (idx2[b*IW +: IW] < IW'(DC))); // R4
    for (genvar j = 0; j < DC; j++) begin : g_bound
      AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst) v1 |=> (m1_2[b*W +: W] <= $past(sh1[(j*Q+b)*W +: W]))); // R4
    end
  end
endmodule

// File: tb/cn_min_front_tb.sv
module cn_min_front_tb_top;
  localparam int P  = 2;
  localparam int DC = 6;
  localparam int W  = 6;
  localparam int Q  = 1 << P;
  localparam int VB = DC*Q*W;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [VB-1:0] in_llr = '0;
  logic [DC*P-1:0] in_hard = '0;
  logic out_valid;
  logic [VB-1:0] out_msg;
  logic [DC*P-1:0] out_hard;
  logic [P-1:0] out_sum;

  cn_min_front #(.P(P), .DC(DC), .W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .in_hard(in_hard), .out_valid(out_valid),
    .out_msg(out_msg), .out_hard(out_hard), .out_sum(out_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int n_vec = 0;
  bit done = 0;
  bit checking = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [VB-1:0]   q_msg[$];
  logic [DC*P-1:0] q_hard[$];
  logic [P-1:0]    q_sum[$];
  int              q_tag[$];

  // Expected exclusion vectors from the requirements
  function automatic logic [VB-1:0] model_msg(input logic [VB-1:0] llr,
                                              input logic [DC*P-1:0] hard);
    logic [VB-1:0] r;
    r = '0;
    for (int b = 1; b < Q; b++) begin
      int best, second, where;
      best = 1 << W; second = 1 << W; where = 0;
      for (int j = 0; j < DC; j++) begin
        int s, v;
        s = b ^ int'(hard[j*P +: P]);
        v = int'(llr[(j*Q+s)*W +: W]);
        if (v < best) begin second = best; best = v; where = j; end
        else if (v < second) second = v;
      end
      for (int j = 0; j < DC; j++)
        r[(j*Q+b)*W +: W] = (j == where) ? W'(second) : W'(best);
    end
    return r;
  endfunction

  function automatic logic [P-1:0] model_sum(input logic [DC*P-1:0] hard);
    logic [P-1:0] s;
    s = '0;
    for (int j = 0; j < DC; j++) s = s ^ hard[j*P +: P];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VB-1:0] act, input logic [VB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (checking) begin
      check(in_ready == 1'b1, "R7", "in_ready", VB'(in_ready), VB'(1));
      if (out_valid) begin
        if (q_tag.size() == 0 || q_tag[0] + 3 != cyc) begin
          check(0, "R7", "unexpected out_valid at cycle", VB'(cyc),
                VB'(q_tag.size() ? q_tag[0] + 3 : -1));
        end else begin
          logic [VB-1:0] em, z;
          em = q_msg.pop_front();
          check(out_hard == q_hard[0], "R2", "out_hard", VB'(out_hard), VB'(q_hard[0]));
          check(out_sum == q_sum[0], "R1", "out_sum", VB'(out_sum), VB'(q_sum[0]));
          check(out_msg == em, "R3 R4 R5", "out_msg", out_msg, em);
          z = '0;
          for (int j = 0; j < DC; j++) z[(j*Q)*W +: W] = out_msg[(j*Q)*W +: W];
          check(z == '0, "R6", "offset0 entries", z, '0);
          void'(q_hard.pop_front()); void'(q_sum.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_tag.size() != 0 && q_tag[0] + 3 == cyc) begin
        check(0, "R7", "missing out_valid at cycle", VB'(cyc), VB'(q_tag[0] + 3));
        void'(q_msg.pop_front()); void'(q_hard.pop_front());
        void'(q_sum.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_up();
    end
  end

  task automatic send(input logic [VB-1:0] llr, input logic [DC*P-1:0] hard);
    @(negedge clk);
    in_valid = 1'b1; in_llr = llr; in_hard = hard;
    q_msg.push_back(model_msg(llr, hard));
    q_hard.push_back(hard);
    q_sum.push_back(model_sum(hard));
    q_tag.push_back(cyc);
    n_vec++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Build an input from values given in the shifted domain
  logic [VB-1:0] sh_tab;
  task automatic send_shifted(input logic [DC*P-1:0] hard);
    logic [VB-1:0] llr;
    llr = '0;
    for (int j = 0; j < DC; j++)
      for (int b = 0; b < Q; b++) begin
        int s;
        s = b ^ int'(hard[j*P +: P]);
        llr[(j*Q+s)*W +: W] = (b == 0) ? '0 : sh_tab[(j*Q+b)*W +: W];
      end
    send(llr, hard);
  endtask

  function automatic logic [DC*P-1:0] rand_hard();
    logic [DC*P-1:0] h;
    for (int j = 0; j < DC; j++) h[j*P +: P] = P'($urandom % Q);
    return h;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8", "out_valid in reset", VB'(out_valid), '0);
    check(in_ready == 1'b0, "R8", "in_ready in reset", VB'(in_ready), '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "in_ready after reset", VB'(in_ready), VB'(1));
    checking = 1;

    // All equal: ties, lowest position wins, second equals first (R4)
    for (int k = 0; k < VB/W; k++) sh_tab[k*W +: W] = W'(5);
    send_shifted('0);
    // Unique minimum at the last position (R4 R5)
    for (int j = 0; j < DC; j++)
      for (int b = 0; b < Q; b++) sh_tab[(j*Q+b)*W +: W] = W'((DC - j) * 5 + b);
    send_shifted(rand_hard());
    // All maximum values
    sh_tab = '1;
    send_shifted(rand_hard());
    // Minimum shared by positions 2 and 4 (R4)
    for (int j = 0; j < DC; j++)
      for (int b = 0; b < Q; b++)
        sh_tab[(j*Q+b)*W +: W] = (j == 2 || j == 4) ? W'(1) : W'(30);
    send_shifted(rand_hard());
    // Hard decisions whose XOR is zero (R1)
    for (int j = 0; j < DC; j++)
      for (int b = 0; b < Q; b++) sh_tab[(j*Q+b)*W +: W] = W'($urandom % 64);
    send_shifted({P'(1), P'(1), P'(2), P'(2), P'(3), P'(3)});
    idle(5);

    // Random traffic with occasional gaps (R3 R7)
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < VB/W; k++) sh_tab[k*W +: W] = W'($urandom % 64);
      send_shifted(rand_hard());
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(8);
    check(q_tag.size() == 0, "R7", "results outstanding", VB'(q_tag.size()), '0);
    finish_up();
  end
endmodule